// File: doc/BRIEF.md
# Nine-Bit Serial Display Link Transmitter

This block turns a stream of display bytes into a write-only serial link for a panel controller that expects a data/command flag in front of every byte. Each accepted item is a flag plus an eight-bit payload. Together they form a nine-bit word: the flag goes out first, then the payload most significant bit first. The flag is 0 for a command byte and 1 for a parameter or pixel byte. The serial clock idles low. The line is sampled on rising edges and changes after falling edges. The select line is active low and stays asserted across a command and all of its parameters until the host asks for a flush.

A static `pack_mode` input picks one of two wire formats for the same item stream. When it is low, every item goes out as its own nine-clock burst. When it is high, the link serves receivers that only take eight-bit transfers. Eight items are collected into a 72-bit group, with the first item at the top of the group. The group is then sent as nine separate eight-clock bursts, highest byte first. A flush ends the frame. If a group is partly filled at that point, the empty slots are padded with all-zero words, which act as no-operation commands, so that all nine bytes still go out. The select line is then released.

The controller has five states. **IDLE** accepts items and flush requests. **NINE** shifts one native word. **LAUNCH** starts one byte of a group. **BYTE** waits for that byte to finish. **DESELECT** releases the select line for one cycle. The transitions are as follows. IDLE→NINE on a native item. IDLE→LAUNCH on the eighth item of a group, or on a flush while a group is partly filled. IDLE→DESELECT on a flush while the select line is low and nothing is pending. NINE→IDLE at the end of the word. LAUNCH→BYTE always. BYTE→LAUNCH while bytes remain. BYTE→IDLE after the ninth byte of a group that filled up normally. BYTE→DESELECT after the ninth byte of a flushed group. DESELECT→IDLE always.

Top module: `ninebit_link_tx`

## Requirements
- R1: In native mode each item is sent as nine bits: the flag first (0 command, 1 parameter), then the payload from bit 7 down to bit 0.
- R2: In native mode each item forms one continuous burst of exactly nine clock pulses, and consecutive items are separated by a longer idle gap.
- R3: In pack mode eight items form a 72-bit group with the first item in bits 71..63, sent as nine eight-pulse bursts from bits 71..64 downward, so the bit order on the wire equals the native nine-bit concatenation.
- R4: In pack mode the eighth item of a group starts transmission of the group without any flush, and the select line stays low afterwards.
- R5: A flush in pack mode with a partly filled group pads each empty slot with nine zero bits (flag 0, payload 0x00), sends all nine bytes and then raises `cs_n`.
- R6: A flush with no group pending sends no clock pulses; it raises `cs_n` if it was low and leaves it high otherwise.
- R7: The serial clock idles low, each of its high and low phases lasts CLK_HALF system cycles, and `mosi` holds steady from before each rising edge until the following falling edge.
- R8: `cs_n` goes low in the cycle after the first item of a frame is accepted, stays low until a flush completes, and no clock pulse occurs while it is high.
- R9: `in_ready` is low while a word or byte is being shifted and while `flush` is high. In native mode it returns 18*CLK_HALF cycles after the accepting edge. A flush acts only in a cycle in which the block is idle.
- R10: After reset `cs_n` is 1, `sclk` is 0, `mosi` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pack_mode | input | 1 | Static: 0 sends nine-bit words, 1 packs eight words into nine bytes |
| in_valid | input | 1 | An item is offered |
| in_dc | input | 1 | Item flag: 0 command, 1 parameter |
| in_data | input | 8 | Item payload |
| in_ready | output | 1 | Item accepted on a cycle with in_valid high |
| flush | input | 1 | End of frame request, acts only when the block is idle |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low select |

## Verification
An item accepted on clock edge E drops `in_ready` and `cs_n` at that edge. The first serial clock rise follows CLK_HALF edges later. In native mode `in_ready` returns at edge E+18*CLK_HALF. The bench samples on falling system-clock edges and counts them from E, so each of these values is compared exactly one half cycle after the edge that sets it. Bit content, burst lengths and padding are compared only after a frame has finished. The wire is captured at every serial clock rise, and the gap between rises marks the word or byte boundaries: 2*CLK_HALF cycles inside a burst, more between bursts.

// File: rtl/ninebit_link_pkg.sv
package ninebit_link_pkg;
    localparam int PAY_BITS    = 8;
    localparam int WORD_BITS   = PAY_BITS + 1;
    localparam int GROUP_WORDS = 8;
    localparam int GROUP_BITS  = GROUP_WORDS * WORD_BITS;
    localparam int GROUP_BYTES = GROUP_BITS / PAY_BITS;
    localparam int SLOT_W      = $clog2(GROUP_WORDS + 1);
    localparam int BYTE_SEL_W  = $clog2(GROUP_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NINE,
        ST_LAUNCH,
        ST_BYTE,
        ST_DESELECT
    } link_state_t;
endpackage

// File: rtl/link_tick_gen.sv
module link_tick_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/link_shifter.sv
module link_shifter
    import ninebit_link_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 nine,
    input  logic [WORD_BITS-1:0] word,
    output logic                 done,
    output logic                 sclk,
    output logic                 mosi
);
    localparam int LEFT_W = $clog2(WORD_BITS);

    logic [WORD_BITS-1:0] sh_q;
    logic [LEFT_W-1:0]    left_q;
    logic                 busy_q;
    logic                 sclk_q;
    logic                 tick;

    link_tick_gen #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .tick  (tick)
    );

    assign done = busy_q && tick && sclk_q && (left_q == '0);
    assign sclk = sclk_q;
    assign mosi = sh_q[WORD_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
        end else if (start && !busy_q) begin
            sh_q   <= word;
            left_q <= nine ? LEFT_W'(WORD_BITS - 1) : LEFT_W'(PAY_BITS - 1);
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
        end else if (busy_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (left_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    sh_q   <= {sh_q[WORD_BITS-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/link_packer.sv
module link_packer
    import ninebit_link_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  clr,
    input  logic                  dc,
    input  logic [PAY_BITS-1:0]   data,
    input  logic [BYTE_SEL_W-1:0] byte_sel,
    output logic [SLOT_W-1:0]     slot_cnt,
    output logic [PAY_BITS-1:0]   byte_out
);
    logic [GROUP_BITS-1:0] flat;

    for (genvar s = 0; s < GROUP_WORDS; s++) begin : g_slot
        logic [WORD_BITS-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clr) begin
                word_q <= '0;
            end else if (wr && (slot_cnt == SLOT_W'(s))) begin
                word_q <= {dc, data};
            end
        end

        assign flat[GROUP_BITS-1-WORD_BITS*s -: WORD_BITS] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt <= '0;
        end else if (clr) begin
            slot_cnt <= '0;
        end else if (wr) begin
            slot_cnt <= slot_cnt + 1'b1;
        end
    end

    always_comb begin
        byte_out = PAY_BITS'(flat >> (GROUP_BITS - PAY_BITS * (int'(byte_sel) + 1)));
    end
endmodule

// File: rtl/ninebit_link_tx.sv
module ninebit_link_tx
    import ninebit_link_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pack_mode,
    input  logic                in_valid,
    input  logic                in_dc,
    input  logic [PAY_BITS-1:0] in_data,
    output logic                in_ready,
    input  logic                flush,
    output logic                sclk,
    output logic                mosi,
    output logic                cs_n
);
    localparam logic [BYTE_SEL_W-1:0] LAST_BYTE = BYTE_SEL_W'(GROUP_BYTES - 1);
    localparam logic [SLOT_W-1:0]     LAST_SLOT = SLOT_W'(GROUP_WORDS - 1);

    link_state_t            state_q, state_d;
    logic                   cs_n_q;
    logic                   flushing_q;
    logic [BYTE_SEL_W-1:0]  byte_q;

    logic                   accept;
    logic                   eng_start, eng_nine, eng_done;
    logic [WORD_BITS-1:0]   eng_word;
    logic                   pk_wr, pk_clr;
    logic [SLOT_W-1:0]      pk_cnt;
    logic [PAY_BITS-1:0]    pk_byte;

    assign in_ready = (state_q == ST_IDLE) && !flush;
    assign accept   = in_valid && in_ready;
    assign cs_n     = cs_n_q;

    link_shifter #(.HALF(CLK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .nine  (eng_nine),
        .word  (eng_word),
        .done  (eng_done),
        .sclk  (sclk),
        .mosi  (mosi)
    );

    link_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (pk_wr),
        .clr      (pk_clr),
        .dc       (in_dc),
        .data     (in_data),
        .byte_sel (byte_q),
        .slot_cnt (pk_cnt),
        .byte_out (pk_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush) begin
                    if (pack_mode && (pk_cnt != '0)) begin
                        state_d = ST_LAUNCH;
                    end else if (!cs_n_q) begin
                        state_d = ST_DESELECT;
                    end
                end else if (in_valid) begin
                    if (!pack_mode) begin
                        state_d = ST_NINE;
                    end else if (pk_cnt == LAST_SLOT) begin
                        state_d = ST_LAUNCH;
                    end
                end
            end
            ST_NINE: begin
                if (eng_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_BYTE;
            end
            ST_BYTE: begin
                if (eng_done) begin
                    if (byte_q != LAST_BYTE) begin
                        state_d = ST_LAUNCH;
                    end else if (flushing_q) begin
                        state_d = ST_DESELECT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_DESELECT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // per-state outputs
    always_comb begin
        eng_start = 1'b0;
        eng_nine  = 1'b1;
        eng_word  = {in_dc, in_data};
        pk_wr     = 1'b0;
        pk_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                eng_start = accept && !pack_mode;
                pk_wr     = accept && pack_mode;
            end
            ST_NINE: begin
            end
            ST_LAUNCH: begin
                eng_start = 1'b1;
                eng_nine  = 1'b0;
                eng_word  = {pk_byte, 1'b0};
            end
            ST_BYTE: begin
                pk_clr = eng_done && (byte_q == LAST_BYTE);
            end
            ST_DESELECT: begin
            end
            default: begin
            end
        endcase
    end

    // select line, byte index and flush marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q     <= 1'b1;
            flushing_q <= 1'b0;
            byte_q     <= '0;
        end else begin
            if (state_d == ST_DESELECT) begin
                cs_n_q <= 1'b1;
            end else if (accept) begin
                cs_n_q <= 1'b0;
            end

            if ((state_q == ST_IDLE) && flush && pack_mode && (pk_cnt != '0)) begin
                flushing_q <= 1'b1;
            end else if (pk_clr) begin
                flushing_q <= 1'b0;
            end

            if ((state_q == ST_BYTE) && eng_done) begin
                byte_q <= (byte_q == LAST_BYTE) ? '0 : byte_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/link_checker.sv
module link_checker (
    input logic clk,
    input logic rst_n,
    input logic pack_mode,
    input logic in_valid,
    input logic in_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    assert_clock_needs_select_R8: assert property (
        @(posedge clk) disable iff (!rst_n) sclk |-> !cs_n
    );

    assert_data_held_high_R7: assert property (
        @(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)
    );

    assert_data_held_rise_R7: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(mosi)
    );

    assert_ready_quiet_R9: assert property (
        @(posedge clk) disable iff (!rst_n) sclk |-> !in_ready
    );

    assert_select_after_accept_R8: assert property (
        @(posedge clk) disable iff (!rst_n) (in_valid && in_ready && !pack_mode) |=> !cs_n
    );
endmodule

bind ninebit_link_tx link_checker u_link_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pack_mode (pack_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n)
);

// File: tb/ninebit_link_tx_bench.sv
module ninebit_link_tx_bench;
    localparam int H     = 2;
    localparam int NVEC  = 16;
    localparam int CAPN  = 1024;

    // {flush_after, flag, payload}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h2A}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'h05},
        {1'b0, 1'b1, 8'h00}, {1'b1, 1'b1, 8'hAF},
        {1'b1, 1'b0, 8'h29},
        {1'b0, 1'b0, 8'h2C}, {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b1, 8'h5A},
        {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'h81},
        {1'b0, 1'b1, 8'h7E}, {1'b0, 1'b1, 8'hC3}, {1'b0, 1'b1, 8'h3C},
        {1'b1, 1'b1, 8'h01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pack_mode = 1'b0;
    logic in_valid = 1'b0;
    logic in_dc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic flush = 1'b0;
    logic in_ready, sclk, mosi, cs_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int cap_n = 0;
    int stray = 0;
    logic sclk_d = 1'b0;
    logic cap_bit [CAPN];
    int   cap_t   [CAPN];

    always #10 clk = ~clk;

    ninebit_link_tx #(.CLK_HALF(H)) u_ninebit_link_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pack_mode (pack_mode),
        .in_valid  (in_valid),
        .in_dc     (in_dc),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .flush     (flush),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n)
    );

    // wire monitor: records every serial clock rise
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk && !sclk_d) begin
            if (cs_n) begin
                stray = stray + 1;
            end else if (cap_n < CAPN) begin
                cap_bit[cap_n] = mosi;
                cap_t[cap_n]   = cyc;
                cap_n = cap_n + 1;
            end
        end
        sclk_d = sclk;
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        pack_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic dc, input logic [7:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_dc = dc;
        in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_flush;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        while (!(in_ready && cs_n)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // expected bit k of a frame made of items first..first+n-1; padding is zero
    function automatic logic exp_bit(input int first, input int n, input int k);
        int item = k / 9;
        if (item >= n) return 1'b0;
        return VEC[first + item][8 - (k % 9)];
    endfunction

    task automatic check_frame(input int first, input int n, input logic mode,
                               input int base, input int sbase);
        int unit = mode ? 8 : 9;
        int nb = mode ? ((n + 7) / 8) * 72 : n * 9;
        int got;
        int bad = 0;
        int badgap = 0;
        @(posedge clk);
        got = cap_n - base;
        chk(got == nb, mode ? "R3 bit count" : "R1 bit count", got, nb);
        for (int k = 0; k < got && k < nb; k++) begin
            if (cap_bit[base + k] !== exp_bit(first, n, k)) bad = bad + 1;
        end
        chk(bad == 0, mode ? "R5 packed content with padding" : "R1 word content", bad, 0);
        for (int k = 1; k < got; k++) begin
            if (((cap_t[base + k] - cap_t[base + k - 1]) > 2 * H) != ((k % unit) == 0))
                badgap = badgap + 1;
        end
        chk(badgap == 0, mode ? "R3 byte bursts" : "R2 word bursts", badgap, 0);
        chk(stray == sbase, "R8 no clock while deselected", stray - sbase, 0);
        chk(cs_n == 1'b1, "R5 select released after flush", int'(cs_n), 1);
    endtask

    initial begin
        int base;
        int sbase;
        int first;

        // R10 reset state
        do_reset(1'b0);
        chk(cs_n == 1'b1, "R10 cs_n after reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R10 sclk after reset", int'(sclk), 0);
        chk(mosi == 1'b0, "R10 mosi after reset", int'(mosi), 0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);

        // vector table walked in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            @(posedge clk);
            base = cap_n;
            sbase = stray;
            first = 0;
            for (int i = 0; i < NVEC; i++) begin
                send(VEC[i][8], VEC[i][7:0]);
                if (VEC[i][9]) begin
                    do_flush();
                    check_frame(first, i - first + 1, m[0], base, sbase);
                    @(posedge clk);
                    base = cap_n;
                    sbase = stray;
                    first = i + 1;
                end
            end
        end

        // R9 / R7 / R8 native timing, counted in falling edges after the accepting edge
        do_reset(1'b0);
        @(posedge clk);
        base = cap_n;
        @(negedge clk);
        in_valid = 1'b1;
        in_dc = 1'b1;
        in_data = 8'hC3;
        for (int j = 1; j <= 18 * H + 1; j++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (j == 1) begin
                chk(in_ready == 1'b0, "R9 ready drops after accept", int'(in_ready), 0);
                chk(cs_n == 1'b0, "R8 select low after accept", int'(cs_n), 0);
            end
            if (j == H) chk(sclk == 1'b0, "R7 clock low for half period", int'(sclk), 0);
            if (j == H + 1) chk(sclk == 1'b1, "R7 first rise after half period", int'(sclk), 1);
            if (j == 18 * H) chk(in_ready == 1'b0, "R9 ready low until word ends", int'(in_ready), 0);
            if (j == 18 * H + 1) chk(in_ready == 1'b1, "R9 ready back after word", int'(in_ready), 1);
        end
        do_flush();
        @(posedge clk);
        chk(cap_n - base == 9, "R1 single word bits", cap_n - base, 9);
        chk(cap_bit[base] == 1'b1, "R1 parameter flag first", int'(cap_bit[base]), 1);

        // R6 flush with nothing pending while deselected
        do_reset(1'b1);
        @(posedge clk);
        base = cap_n;
        do_flush();
        repeat (10) @(negedge clk);
        @(posedge clk);
        chk(cap_n == base, "R6 empty flush sends nothing", cap_n - base, 0);
        chk(cs_n == 1'b1, "R6 empty flush keeps select high", int'(cs_n), 1);

        // R4 full group goes out without flush
        @(posedge clk);
        base = cap_n;
        for (int i = 0; i < 8; i++) send(VEC[6 + i][8], VEC[6 + i][7:0]);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        @(posedge clk);
        chk(cap_n - base == 72, "R4 group sent without flush", cap_n - base, 72);
        chk(cs_n == 1'b0, "R4 select stays low after group", int'(cs_n), 0);
        begin
            int bad = 0;
            for (int k = 0; k < 72; k++)
                if (cap_bit[base + k] !== exp_bit(6, 8, k)) bad = bad + 1;
            chk(bad == 0, "R3 group bit order", bad, 0);
        end
        do_flush();
        @(posedge clk);
        chk(cap_n - base == 72, "R6 flush of empty group adds no bits", cap_n - base, 72);
        chk(cs_n == 1'b1, "R6 flush releases select", int'(cs_n), 1);

        report();
    end
endmodule